// File: doc/BRIEF.md
# Warp Issue Scheduler

This block is the issue stage of one GPU sub-core. Each clock it looks at the oldest waiting warp instruction. That instruction arrives on a valid/ready handshake with a 3-bit code naming the execution unit it needs. The block sends it to that unit's pipeline only if the pipeline has finished the occupancy window of its previous instruction. Each pipeline has its own countdown, so work for different units can go out on consecutive clocks. A second instruction for the same unit must wait until that unit's window has run out.

Issue is strictly in order. When the head instruction's pipeline is still occupied, the block holds it, drops ready, raises a stall flag and lets nothing younger pass. A mode input turns the integer pipeline into a mixed pipeline. That pipeline then also takes floating-point work, so floating-point instructions can alternate between two pipes and go out every clock. Operand reads, hazards and the arithmetic itself belong to other blocks.

Top module: `warp_issue_sched`

## Requirements
- R1: At most one instruction is dispatched per clock: `dispatch` is zero or one-hot. `in_ready` is high exactly when the head instruction is taken that cycle.
- R2: Class codes on `in_cls` are 0 = FP32, 1 = INT, 2 = SFU, 3 = tensor and 4 = load/store. `dispatch` bit 0 is the FP32 pipe, bit 1 the INT (or mixed) pipe, bit 2 the SFU, bit 3 the tensor pipe and bit 4 the load/store pipe. Codes 0 to 4 route to the bit of the same number, except FP32 in mixed mode (R8).
- R3: After a pipeline is granted, it can be granted again no sooner than its occupancy in cycles later. It is granted exactly then if the head is waiting for it. The default occupancies are FP32 2, INT 2, SFU 8, tensor 8 and load/store 2.
- R4: An instruction for a different, free pipeline issues on the very next cycle after a dispatch.
- R5: While the head instruction's pipeline is occupied, `stall` is 1, `in_ready` is 0 and `dispatch` is 0. No later instruction issues ahead of it.
- R6: `busy` bit p is 1 for the occupancy minus one cycles that follow a grant of pipe p, and 0 otherwise.
- R7: Reset, applied at any time, clears every countdown at once: `busy` and `dispatch` read 0.
- R8: With `hybrid_en` = 1, an FP32 instruction goes to pipe 0 if it is free, otherwise to pipe 1 if that is free. INT still uses only pipe 1, so FP32 instructions can issue on every clock.
- R9: Reserved codes 5 to 7 are taken in one cycle with no dispatch, and they leave every countdown unchanged.
- R10: With the default occupancies, a tensor instruction can be followed by seven alternating FP32/INT instructions and then a second tensor instruction with no stall. With FP32 only, four fit between the two tensor issues, at the cost of three stall cycles.
- R11: `stall` is 0 whenever `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hybrid_en | input | 1 | 1: pipe 1 takes both FP32 and INT work |
| in_valid | input | 1 | Head instruction present |
| in_cls | input | 3 | Execution-unit class of the head instruction |
| in_ready | output | 1 | Head instruction taken this cycle |
| dispatch | output | 5 | One-hot grant to a pipeline this cycle |
| stall | output | 1 | Head present but its pipeline is occupied |
| busy | output | 5 | Per-pipeline countdown is nonzero |

## Verification
A countdown left nonzero too long shows at the ports as one or more extra stall cycles. It also delays the grant for the next instruction of that class. A countdown that clears early shows as a grant earlier than the occupancy allows. Either fault appears on the first reissue to that pipe, so the bench compares the cycle and the pipe of every dispatch with a model kept as last-issue times. Wrong routing shows at once as the wrong `dispatch` bit. A reserved code that disturbs the countdowns shows as a changed `busy` vector one cycle later.

// File: rtl/wis_pkg.sv
package wis_pkg;

  localparam int NPIPE = 5;

  // Pipe indices used for the dispatch and busy vectors
  localparam int P_FP  = 0;
  localparam int P_INT = 1;
  localparam int P_SFU = 2;
  localparam int P_TC  = 3;
  localparam int P_LS  = 4;

  typedef enum logic [2:0] {
    CLS_FP32   = 3'd0,
    CLS_INT    = 3'd1,
    CLS_SFU    = 3'd2,
    CLS_TENSOR = 3'd3,
    CLS_LDST   = 3'd4
  } wis_cls_e;

  // Codes above the last defined class carry no work
  function automatic logic cls_reserved(input logic [2:0] cls);
    return cls > 3'd4;
  endfunction

  // Choose the target pipe for a class, given which pipes are free
  function automatic logic [NPIPE-1:0] pick_pipe(input logic [2:0] cls,
                                                 input logic [NPIPE-1:0] free,
                                                 input logic hyb);
    logic [NPIPE-1:0] g;
    g = '0;
    case (cls)
      CLS_FP32: begin
        if (free[P_FP])              g[P_FP]  = 1'b1;
        else if (hyb && free[P_INT]) g[P_INT] = 1'b1;
      end
      CLS_INT:    if (free[P_INT]) g[P_INT] = 1'b1;
      CLS_SFU:    if (free[P_SFU]) g[P_SFU] = 1'b1;
      CLS_TENSOR: if (free[P_TC])  g[P_TC]  = 1'b1;
      CLS_LDST:   if (free[P_LS])  g[P_LS]  = 1'b1;
      default:    g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/wis_countdown.sv
module wis_countdown #(
  parameter int OCC = 2,
  parameter int CW  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic busy
);

  localparam logic [CW-1:0] RELOAD = CW'(OCC - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] cur, input logic ld);
    if (ld)        return RELOAD;
    if (cur != '0) return cur - CW'(1);
    return cur;
  endfunction

  always_comb cnt_nx = step(cnt, grant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  assign busy = (cnt != '0);

  // R3: the router never grants an occupied pipe
  a_r3_no_grant_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !grant);

  // R3: a grant opens a full occupancy window
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (cnt == RELOAD));

  // R6: an open window shrinks by one each cycle
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !grant) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/wis_route.sv
module wis_route
  import wis_pkg::*;
(
  input  logic             in_valid,
  input  logic [2:0]       in_cls,
  input  logic             hybrid_en,
  input  logic [NPIPE-1:0] pipe_busy,
  output logic [NPIPE-1:0] grant,
  output logic             accept,
  output logic             stall
);

  logic [NPIPE-1:0] pipe_free;
  logic [NPIPE-1:0] want;
  logic             drop_code;

  assign pipe_free = ~pipe_busy;
  assign want      = pick_pipe(in_cls, pipe_free, hybrid_en);
  assign drop_code = cls_reserved(in_cls);

  assign grant  = in_valid ? want : '0;
  assign accept = in_valid && ((|grant) || drop_code);
  assign stall  = in_valid && !accept;

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int OCC_FP32   = 2,
  parameter int OCC_INT    = 2,
  parameter int OCC_SFU    = 8,
  parameter int OCC_TENSOR = 8,
  parameter int OCC_LDST   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hybrid_en,
  input  logic       in_valid,
  input  logic [2:0] in_cls,
  output logic       in_ready,
  output logic [4:0] dispatch,
  output logic       stall,
  output logic [4:0] busy
);

  function automatic int occ_of(input int p);
    case (p)
      P_FP:    return OCC_FP32;
      P_INT:   return OCC_INT;
      P_SFU:   return OCC_SFU;
      P_TC:    return OCC_TENSOR;
      default: return OCC_LDST;
    endcase
  endfunction

  function automatic int occ_max();
    int m;
    m = 1;
    for (int p = 0; p < NPIPE; p++) if (occ_of(p) > m) m = occ_of(p);
    return m;
  endfunction

  localparam int OCC_MAX = occ_max();
  localparam int CW      = (OCC_MAX > 1) ? $clog2(OCC_MAX) : 1;

  logic [NPIPE-1:0] grant;
  logic [NPIPE-1:0] pipe_busy;
  logic             accept;
  logic             stall_w;

  wis_route u_route (
    .in_valid  (in_valid),
    .in_cls    (in_cls),
    .hybrid_en (hybrid_en),
    .pipe_busy (pipe_busy),
    .grant     (grant),
    .accept    (accept),
    .stall     (stall_w)
  );

  for (genvar gp = 0; gp < NPIPE; gp++) begin : g_pipe
    wis_countdown #(.OCC(occ_of(gp)), .CW(CW)) u_cd (
      .clk   (clk),
      .rst_n (rst_n),
      .grant (grant[gp]),
      .busy  (pipe_busy[gp])
    );
  end

  assign in_ready = accept;
  assign dispatch = grant;
  assign stall    = stall_w;
  assign busy     = pipe_busy;

  // R1: one dispatch per clock at most
  a_r1_single_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dispatch));

  // R5: a stalled head moves nothing
  a_r5_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (dispatch == '0 && !in_ready));

  // R11: no stall without a head instruction
  a_r11_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !stall);

  // R9: reserved codes pass through without work
  a_r9_reserved_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cls > 3'd4) |-> (in_ready && dispatch == '0));

  // R2: pipe 0 only ever takes FP32 work
  a_r2_fp_pipe_class: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch[P_FP] |-> (in_cls == CLS_FP32));

  // R8: outside mixed mode pipe 1 only takes INT work
  a_r8_int_pipe_class: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch[P_INT] && !hybrid_en) |-> (in_cls == CLS_INT));

endmodule

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hybrid_en;
  logic       in_valid;
  logic [2:0] in_cls;
  wire        in_ready;
  wire  [4:0] dispatch;
  wire        stall;
  wire  [4:0] busy;

  always #5 clk = ~clk;

  warp_issue_sched i_warp_issue_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .hybrid_en (hybrid_en),
    .in_valid  (in_valid),
    .in_cls    (in_cls),
    .in_ready  (in_ready),
    .dispatch  (dispatch),
    .stall     (stall),
    .busy      (busy)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int occ [5] = '{2, 2, 8, 8, 2};
  int last [5];
  int q_cyc [$];
  int q_pipe [$];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int p = 0; p < 5; p++) last[p] = -100;
  endtask

  // A pipe is open when its occupancy has passed since its last issue
  function automatic bit open_at(input int p, input int c);
    return (c - last[p]) >= occ[p];
  endfunction

  // Driver: predicts dispatch cycle and pipe, pushes them, then offers the instruction
  task automatic issue(input int cls, inout int stalls);
    int c;
    int p;
    if (cls <= 4) begin
      c = cyc;
      p = -1;
      while (p < 0) begin
        if (cls == 0) begin
          if (open_at(0, c))                  p = 0;
          else if (hybrid_en && open_at(1, c)) p = 1;
        end else if (open_at(cls, c)) p = cls;
        if (p < 0) c++;
      end
      last[p] = c;
      q_cyc.push_back(c);
      q_pipe.push_back(p);
    end
    in_valid = 1'b1;
    in_cls   = cls[2:0];
    forever begin
      #1;
      if (in_ready) break;
      stalls++;
      chk(stall === 1'b1 && dispatch === 5'd0, "R5 stall while head blocked", int'(stall), 1);
      @(negedge clk);
    end
    if (cls > 4) chk(dispatch === 5'd0, "R9 reserved code dispatches nothing", int'(dispatch), 0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the expected dispatch for every grant it sees
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (dispatch !== 5'd0) begin
        if (q_cyc.size() == 0) begin
          chk(1'b0, "R1 unexpected dispatch", int'(dispatch), 0);
        end else begin
          int ec;
          int ep;
          ec = q_cyc.pop_front();
          ep = q_pipe.pop_front();
          chk(dispatch === 5'(1 << ep), "R2 dispatch pipe", int'(dispatch), 1 << ep);
          chk(cyc == ec, "R3 R4 dispatch cycle", cyc, ec);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s;
    rst_n     = 1'b0;
    hybrid_en = 1'b0;
    in_valid  = 1'b0;
    in_cls    = 3'd0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy === 5'd0, "R7 busy clear after reset", int'(busy), 0);
    chk(dispatch === 5'd0 && stall === 1'b0 && in_ready === 1'b0,
        "R11 idle outputs after reset", int'(stall), 0);
    @(negedge clk);

    // Same pipe twice: one stall cycle (R3)
    s = 0;
    issue(0, s); issue(0, s);
    chk(s == 1, "R3 FP32 reissue waits one cycle", s, 1);
    idle(4);

    // Alternating pipes back to back (R4)
    s = 0;
    issue(0, s); issue(1, s); issue(0, s); issue(1, s); issue(4, s); issue(0, s);
    chk(s == 0, "R4 alternating pipes never stall", s, 0);
    idle(10);

    // SFU interval and busy window (R3, R6)
    s = 0;
    issue(2, s);
    for (int k = 1; k <= 8; k++) begin
      #1;
      chk(busy === ((k <= 7) ? 5'b00100 : 5'b00000), "R6 SFU busy window", int'(busy),
          (k <= 7) ? 4 : 0);
      @(negedge clk);
    end
    issue(2, s); issue(2, s);
    chk(s == 7, "R3 SFU reissue waits seven cycles", s, 7);

    // In-order: FP32 behind a blocked SFU may not pass (R5)
    s = 0;
    issue(2, s); issue(0, s);
    chk(s == 7, "R5 younger FP32 held behind SFU", s, 7);
    idle(10);

    // Load/store interval (R3)
    s = 0;
    issue(4, s); issue(4, s); issue(4, s);
    chk(s == 2, "R3 load/store interval", s, 2);
    idle(10);

    // Tensor budget with interleaving (R10)
    s = 0;
    issue(3, s);
    issue(0, s); issue(1, s); issue(0, s); issue(1, s); issue(0, s); issue(1, s); issue(0, s);
    issue(3, s);
    chk(s == 0, "R10 seven scalars fit between tensor issues", s, 0);
    idle(10);

    // Tensor budget with FP32 only (R10)
    s = 0;
    issue(3, s);
    issue(0, s); issue(0, s); issue(0, s); issue(0, s);
    issue(3, s);
    chk(s == 3, "R10 four FP32 fit between tensor issues", s, 3);
    idle(10);

    // Reserved code leaves the countdowns alone (R9)
    s = 0;
    issue(0, s);
    issue(5, s);
    #1;
    chk(busy === 5'b00000, "R9 busy unchanged after reserved code", int'(busy), 0);
    @(negedge clk);
    issue(7, s);
    issue(0, s); issue(0, s);
    chk(s == 1, "R9 reserved code costs no extra stall", s, 1);
    idle(10);

    // Mixed mode (R8)
    hybrid_en = 1'b1;
    s = 0;
    issue(0, s); issue(0, s); issue(0, s); issue(0, s);
    chk(s == 0, "R8 FP32 every clock in mixed mode", s, 0);
    idle(4);
    s = 0;
    issue(0, s); issue(0, s); issue(1, s);
    chk(s == 1, "R8 INT waits for the shared pipe", s, 1);
    idle(4);
    s = 0;
    issue(1, s); issue(1, s);
    chk(s == 1, "R8 INT interval unchanged in mixed mode", s, 1);
    idle(4);
    hybrid_en = 1'b0;

    // Reset in the middle of a window (R7)
    s = 0;
    issue(2, s);
    rst_n = 1'b0;
    #1;
    chk(busy === 5'd0, "R7 reset clears an open window", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    s = 0;
    issue(2, s);
    chk(s == 0, "R7 SFU free right after reset", s, 0);
    idle(10);

    chk(q_cyc.size() == 0, "R1 every predicted dispatch seen", q_cyc.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule